// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host-side requester of configuration cycles and a set of up to 256 device/function configuration spaces on a single bus. Each request carries a packed address, a byte length and, for writes, the data. The router splits the address into bus, slot and register fields, and checks that the bus is bus 0 and that the slot holds a registered function. If both hold, it raises that slot's select line and passes the register offset, length and write data through in the same cycle. A read that misses returns all-ones sized to the requested length. A write that misses is dropped without any sign at the target side.

The block also keeps its own record of which slots are in use. A registration request either names a slot outright or asks for one to be chosen. In the second case the router searches function 0 of each device, starting at a configured minimum slot, and takes the lowest free one. Every successful registration receives the next interrupt index, counting up from zero. Once a configured number of functions have registered, every further registration is refused.

Top module: `cfg_access_router`

## Requirements
- R1: After reset no slot is occupied, no read response is pending, and the first successful registration is given interrupt index 0.
- R2: Request address bits 23:16 are the bus, bits 15:8 the slot (device = slot bits 7:3, function = slot bits 2:0) and bits 7:0 the register offset. A request to bus 0 that names an occupied slot asserts exactly that slot's bit of `tgt_sel` in the request cycle and presents the offset on `tgt_offset`.
- R3: A request whose bus field is nonzero asserts no `tgt_sel` bit. A read of this kind returns all-ones for its length.
- R4: A read of an unoccupied slot on bus 0 asserts no `tgt_sel` bit and returns length-sized all-ones. `req_len` 0 selects 1 byte (0xFF), 1 selects 2 bytes (0xFFFF), and 2 or 3 select 4 bytes (0xFFFFFFFF). Bits above the length read as zero.
- R5: A write that misses (nonzero bus or empty slot) asserts no `tgt_sel` bit and produces no response.
- R6: A read is answered by a single-cycle `resp_valid` pulse on the clock edge that follows the request cycle. On a hit, the data is `tgt_rdata` with the bytes above the length cleared.
- R7: A write hit forwards `req_wdata` on `tgt_wdata`, `req_len` on `tgt_len` and raises `tgt_write`. A write never raises `resp_valid`.
- R8: An automatic registration grants the lowest free slot among SLOT_MIN, SLOT_MIN+8, SLOT_MIN+16 and so on below 256. If none of these is free, it fails.
- R9: An explicit registration marks the requested slot occupied, so that later requests to that slot hit.
- R10: Interrupt indices are handed out in order, and the counter advances only on a success. Once MAX_DEV registrations have succeeded, every further registration fails and leaves the occupancy unchanged.
- R11: `reg_done` pulses for one cycle on the edge after `reg_valid`, with `reg_ok`, the granted slot on `reg_grant` and its index on `reg_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, slot and register offset |
| req_len | input | 2 | Access length code |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read response pulse |
| resp_rdata | output | 32 | Read response data |
| tgt_sel | output | 256 | One-hot select of the addressed slot |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_offset | output | 8 | Forwarded register offset |
| tgt_len | output | 2 | Forwarded length code |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Read data from the selected configuration space |
| reg_valid | input | 1 | Registration request |
| reg_auto | input | 1 | 1 = choose slot automatically |
| reg_slot | input | 8 | Requested slot when not automatic |
| reg_done | output | 1 | Registration result pulse |
| reg_ok | output | 1 | Registration succeeded |
| reg_grant | output | 8 | Slot granted |
| reg_irq | output | $clog2(MAX_DEV+1) | Interrupt index given |

## Verification
The target-side outputs are combinational in the request cycle, so the bench drives a request on a falling edge and reads `tgt_sel`, `tgt_write`, `tgt_offset` and `tgt_wdata` shortly after. The read response and the registration result each pass through one register. The bench therefore samples them on the next falling edge, which is the first point after the capturing rising edge. It then checks one more falling edge later that `resp_valid` has dropped, which confirms it is a single pulse. Occupancy updates on that same capturing edge, so a request issued in the cycle after `reg_done` already sees the new slot.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      LEN_B1 = 2'd0,
      LEN_B2 = 2'd1,
      LEN_B4 = 2'd2
   } cfg_len_e;

   function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
      case (len)
         LEN_B1:  len_mask = 32'h0000_00FF;
         LEN_B2:  len_mask = 32'h0000_FFFF;
         default: len_mask = 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/cfgrt_decode.sv
module cfgrt_decode #(
   parameter int BUS_W  = 8,
   parameter int SLOT_W = 8,
   parameter int OFF_W  = 8
) (
   input  logic                        req_valid,
   input  logic [BUS_W+SLOT_W+OFF_W-1:0] req_addr,
   input  logic [(1<<SLOT_W)-1:0]      occ,
   output logic                        hit,
   output logic [OFF_W-1:0]            offset,
   output logic [(1<<SLOT_W)-1:0]      sel
);
   localparam int NUM_SLOTS = 1 << SLOT_W;

   logic [BUS_W-1:0]  bus_f;
   logic [SLOT_W-1:0] slot_f;
   logic              bus_ok;

   assign bus_f  = req_addr[BUS_W+SLOT_W+OFF_W-1 -: BUS_W];
   assign slot_f = req_addr[SLOT_W+OFF_W-1 -: SLOT_W];
   assign offset = req_addr[OFF_W-1:0];
   assign bus_ok = (bus_f == '0);
   assign hit    = req_valid && bus_ok && occ[slot_f];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
      assign sel[g] = hit && (slot_f == SLOT_W'(g));
   end
endmodule

// File: rtl/cfgrt_resp.sv
module cfgrt_resp
   import cfgrt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              hit,
   input  logic [1:0]        req_len,
   input  logic [DATA_W-1:0] tgt_rdata,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata
);
   logic [DATA_W-1:0] mask;
   assign mask = len_mask(req_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= req_valid && !req_write;
         if (req_valid && !req_write)
            resp_rdata <= hit ? (tgt_rdata & mask) : mask;
      end
   end

   p_read_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> resp_valid);
   p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !resp_valid);
   p_miss_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !hit) |=> (resp_rdata == $past(mask)));
endmodule

// File: rtl/cfgrt_slot_alloc.sv
module cfgrt_slot_alloc #(
   parameter int SLOT_W   = 8,
   parameter int STEP     = 8,
   parameter int SLOT_MIN = 0,
   parameter int MAX_DEV  = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_valid,
   input  logic                         reg_auto,
   input  logic [SLOT_W-1:0]            reg_slot,
   output logic [(1<<SLOT_W)-1:0]       occ,
   output logic                         reg_done,
   output logic                         reg_ok,
   output logic [SLOT_W-1:0]            reg_grant,
   output logic [$clog2(MAX_DEV+1)-1:0] reg_irq
);
   localparam int NUM_SLOTS = 1 << SLOT_W;
   localparam int NCAND     = NUM_SLOTS / STEP;
   localparam int IDX_W     = $clog2(MAX_DEV + 1);

   if (SLOT_MIN % STEP != 0 || SLOT_MIN >= NUM_SLOTS)
      $error("SLOT_MIN must be a multiple of STEP below the slot count");
   if (NUM_SLOTS % STEP != 0)
      $error("STEP must divide the slot count");

   logic [NUM_SLOTS-1:0] occ_q;
   logic [IDX_W-1:0]     cnt_q;
   logic [NCAND-1:0]     cand_free;
   logic                 pick_found;
   logic [SLOT_W-1:0]    pick_slot;
   logic [SLOT_W-1:0]    tgt_slot;
   logic                 full;
   logic                 grant;

   for (genvar g = 0; g < NCAND; g++) begin : g_cand
      if (g * STEP >= SLOT_MIN) begin : g_on
         assign cand_free[g] = !occ_q[g*STEP];
      end else begin : g_off
         assign cand_free[g] = 1'b0;
      end
   end

   always_comb begin
      pick_found = 1'b0;
      pick_slot  = '0;
      for (int i = NCAND - 1; i >= 0; i--) begin
         if (cand_free[i]) begin
            pick_found = 1'b1;
            pick_slot  = SLOT_W'(i * STEP);
         end
      end
   end

   assign full     = (cnt_q == IDX_W'(MAX_DEV));
   assign tgt_slot = reg_auto ? pick_slot : reg_slot;
   assign grant    = reg_valid && !full && (!reg_auto || pick_found);
   assign occ      = occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q     <= '0;
         cnt_q     <= '0;
         reg_done  <= 1'b0;
         reg_ok    <= 1'b0;
         reg_grant <= '0;
         reg_irq   <= '0;
      end else begin
         reg_done <= reg_valid;
         if (reg_valid) begin
            reg_ok    <= grant;
            reg_grant <= tgt_slot;
            reg_irq   <= cnt_q;
         end
         if (grant) begin
            occ_q[tgt_slot] <= 1'b1;
            cnt_q           <= cnt_q + IDX_W'(1);
         end
      end
   end

   p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |=> reg_done);
   p_cap_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= IDX_W'(MAX_DEV));
   p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && full) |=> ($stable(occ_q) && !reg_ok));
   p_grant_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_done && reg_ok) |-> occ_q[reg_grant]);
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
   import cfgrt_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int SLOT_W   = 8,
   parameter int OFF_W    = 8,
   parameter int STEP     = 8,
   parameter int SLOT_MIN = 0,
   parameter int MAX_DEV  = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_write,
   input  logic [BUS_W+SLOT_W+OFF_W-1:0] req_addr,
   input  logic [1:0]                   req_len,
   input  logic [31:0]                  req_wdata,
   output logic                         resp_valid,
   output logic [31:0]                  resp_rdata,
   output logic [(1<<SLOT_W)-1:0]       tgt_sel,
   output logic                         tgt_write,
   output logic [OFF_W-1:0]             tgt_offset,
   output logic [1:0]                   tgt_len,
   output logic [31:0]                  tgt_wdata,
   input  logic [31:0]                  tgt_rdata,
   input  logic                         reg_valid,
   input  logic                         reg_auto,
   input  logic [SLOT_W-1:0]            reg_slot,
   output logic                         reg_done,
   output logic                         reg_ok,
   output logic [SLOT_W-1:0]            reg_grant,
   output logic [$clog2(MAX_DEV+1)-1:0] reg_irq
);
   localparam int NUM_SLOTS = 1 << SLOT_W;

   if (BUS_W < 1 || SLOT_W < 3 || OFF_W < 1)
      $error("field widths out of range");

   logic [NUM_SLOTS-1:0] occ;
   logic                 hit;

   cfgrt_slot_alloc #(
      .SLOT_W(SLOT_W), .STEP(STEP), .SLOT_MIN(SLOT_MIN), .MAX_DEV(MAX_DEV)
   ) i_alloc (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_auto(reg_auto), .reg_slot(reg_slot),
      .occ(occ), .reg_done(reg_done), .reg_ok(reg_ok),
      .reg_grant(reg_grant), .reg_irq(reg_irq)
   );

   cfgrt_decode #(
      .BUS_W(BUS_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W)
   ) i_decode (
      .req_valid(req_valid), .req_addr(req_addr), .occ(occ),
      .hit(hit), .offset(tgt_offset), .sel(tgt_sel)
   );

   cfgrt_resp i_resp (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .hit(hit),
      .req_len(req_len), .tgt_rdata(tgt_rdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata)
   );

   assign tgt_write = req_valid && req_write;
   assign tgt_len   = req_len;
   assign tgt_wdata = req_wdata;

   p_far_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[BUS_W+SLOT_W+OFF_W-1 -: BUS_W] != '0) |-> (tgt_sel == '0));
   p_sel_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));
   p_sel_on_occupied_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel != '0) |-> ((tgt_sel & ~occ) == '0));
endmodule

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;
   localparam int MAXD = 6;
   localparam int IW   = $clog2(MAXD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [1:0]  req_len = '0;
   logic [31:0] req_wdata = '0;
   logic        resp_valid;
   logic [31:0] resp_rdata;
   logic [255:0] tgt_sel;
   logic        tgt_write;
   logic [7:0]  tgt_offset;
   logic [1:0]  tgt_len;
   logic [31:0] tgt_wdata;
   logic [31:0] tgt_rdata;
   logic        reg_valid = 1'b0, reg_auto = 1'b0;
   logic [7:0]  reg_slot = '0;
   logic        reg_done, reg_ok;
   logic [7:0]  reg_grant;
   logic [IW-1:0] reg_irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cfg_access_router #(.SLOT_MIN(224), .MAX_DEV(MAXD)) i_cfg_access_router (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_len(req_len), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .tgt_sel(tgt_sel), .tgt_write(tgt_write), .tgt_offset(tgt_offset),
      .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
      .reg_valid(reg_valid), .reg_auto(reg_auto), .reg_slot(reg_slot),
      .reg_done(reg_done), .reg_ok(reg_ok), .reg_grant(reg_grant), .reg_irq(reg_irq)
   );

   // target model: data built from the selected slot and offset
   function automatic logic [31:0] model(input logic [7:0] s, input logic [7:0] o);
      return {s, o, ~s, ~o};
   endfunction

   always_comb begin
      tgt_rdata = 32'hDEAD_BEEF;
      for (int i = 0; i < 256; i++)
         if (tgt_sel[i]) tgt_rdata = model(8'(i), tgt_offset);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // returns selected index, or 999 when none; -1 when several
   function automatic int sel_idx();
      int n = 0, k = 999;
      for (int i = 0; i < 256; i++) if (tgt_sel[i]) begin n++; k = i; end
      return (n > 1) ? -1 : k;
   endfunction

   task automatic do_read(input string tag, input logic [7:0] bus, input logic [7:0] slot,
                          input logic [7:0] off, input logic [1:0] len,
                          input int exp_sel, input logic [31:0] exp_data);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = {bus, slot, off}; req_len = len;
      #1;
      chk({tag, " sel"}, 32'(sel_idx()), 32'(exp_sel));
      if (exp_sel != 999) chk({tag, " offset"}, 32'(tgt_offset), 32'(off));
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid R6"}, 32'(resp_valid), 32'd1);
      chk({tag, " data"}, resp_rdata, exp_data);
      @(negedge clk);
      chk({tag, " pulse R6"}, 32'(resp_valid), 32'd0);
   endtask

   task automatic do_write(input string tag, input logic [7:0] bus, input logic [7:0] slot,
                           input logic [7:0] off, input logic [31:0] d, input int exp_sel);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = {bus, slot, off};
      req_len = 2'd2; req_wdata = d;
      #1;
      chk({tag, " sel"}, 32'(sel_idx()), 32'(exp_sel));
      if (exp_sel != 999) begin
         chk({tag, " wdata R7"}, tgt_wdata, d);
         chk({tag, " wflag R7"}, 32'(tgt_write), 32'd1);
         chk({tag, " len R7"}, 32'(tgt_len), 32'd2);
      end
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk({tag, " no resp"}, 32'(resp_valid), 32'd0);
   endtask

   task automatic do_reg(input string tag, input logic aut, input logic [7:0] slot,
                         input logic exp_ok, input logic [7:0] exp_slot, input int exp_irq);
      @(negedge clk);
      reg_valid = 1'b1; reg_auto = aut; reg_slot = slot;
      @(negedge clk);
      reg_valid = 1'b0;
      chk({tag, " done R11"}, 32'(reg_done), 32'd1);
      chk({tag, " ok"}, 32'(reg_ok), 32'(exp_ok));
      if (exp_ok) begin
         chk({tag, " grant R11"}, 32'(reg_grant), 32'(exp_slot));
         chk({tag, " irq R10"}, 32'(reg_irq), 32'(exp_irq));
      end
      @(negedge clk);
      chk({tag, " done pulse R11"}, 32'(reg_done), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 resp idle", 32'(resp_valid), 32'd0);
      chk("R1 done idle", 32'(reg_done), 32'd0);
      do_read("R1 empty after reset", 8'h00, 8'hE0, 8'h00, 2'd2, 999, 32'hFFFF_FFFF);
   endtask

   task automatic t_register();
      do_reg("R9 explicit 13", 1'b0, 8'h13, 1'b1, 8'h13, 0);
      do_reg("R8 auto first", 1'b1, 8'h00, 1'b1, 8'hE0, 1);
      do_reg("R8 auto second", 1'b1, 8'h00, 1'b1, 8'hE8, 2);
      do_reg("R9 explicit F0", 1'b0, 8'hF0, 1'b1, 8'hF0, 3);
      do_reg("R8 auto skips F0", 1'b1, 8'h00, 1'b1, 8'hF8, 4);
      do_reg("R8 auto none free", 1'b1, 8'h00, 1'b0, 8'h00, 0);
      do_reg("R10 explicit 05", 1'b0, 8'h05, 1'b1, 8'h05, 5);
      do_reg("R10 limit reached", 1'b0, 8'h06, 1'b0, 8'h00, 0);
      do_read("R10 refused slot empty", 8'h00, 8'h06, 8'h00, 2'd0, 999, 32'h0000_00FF);
   endtask

   task automatic t_reads();
      do_read("R2 R6 word", 8'h00, 8'h13, 8'h08, 2'd2, 8'h13, model(8'h13, 8'h08));
      do_read("R6 byte", 8'h00, 8'h13, 8'h08, 2'd0, 8'h13, model(8'h13, 8'h08) & 32'hFF);
      do_read("R6 half", 8'h00, 8'hE8, 8'h3C, 2'd1, 8'hE8, model(8'hE8, 8'h3C) & 32'hFFFF);
      do_read("R9 explicit hit", 8'h00, 8'h05, 8'h10, 2'd3, 8'h05, model(8'h05, 8'h10));
      do_read("R3 far bus", 8'h01, 8'h13, 8'h08, 2'd2, 999, 32'hFFFF_FFFF);
      do_read("R3 far bus byte", 8'h80, 8'h13, 8'h00, 2'd0, 999, 32'h0000_00FF);
      do_read("R4 empty half", 8'h00, 8'h07, 8'h00, 2'd1, 999, 32'h0000_FFFF);
      do_read("R4 empty len3", 8'h00, 8'h14, 8'h04, 2'd3, 999, 32'hFFFF_FFFF);
   endtask

   task automatic t_writes();
      do_write("R7 write hit", 8'h00, 8'hE0, 8'h3C, 32'hA5A5_1234, 8'hE0);
      do_write("R5 write far bus", 8'h02, 8'hE0, 8'h3C, 32'h1111_2222, 999);
      do_write("R5 write empty", 8'h00, 8'h30, 8'h04, 32'h3333_4444, 999);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_register();
      t_reads();
      t_writes();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule